// File: doc/BRIEF.md
# Double-Buffered Memory-to-Memory DMA Channel

This block is one memory-to-memory copy channel with two descriptor slots. Each slot holds a source address, a destination address and a byte count. Software loads one or both slots through a small register port. It sets the channel enable and then pulses a start bit. The channel copies one 32-bit word at a time. Each word takes a read phase and then a write phase on a valid/ready memory port. When the active slot runs out and the other slot is loaded, the channel moves to that slot with no pause.

Two state machines are visible in the status register. The buffer machine shows how many slots are loaded. The control machine shows which phase of the copy is running. The done flag is sticky. It can still be set from an earlier run while a restarted channel is moving data. For this reason, software decides that the channel has stopped from the two machine states, and not from the done flag.

Register offsets: control 0x00, interrupt 0x04, status 0x0C, slot 0 count 0x10, slot 1 count 0x14, slot 0 source 0x18, slot 1 source 0x1C, slot 0 destination 0x20, slot 1 destination 0x24. A read returns its data on `reg_rdata` one clock after the address is presented.

Top module: `dma_m2m_chan`

## Requirements
- R1: After reset, the status register (0x0C) reads 0, `irq` is low and `mem_req` is low.
- R2: Writing a nonzero value to a slot's count register loads that slot, and writing zero unloads it. Status bits 5:4 give the buffer state: 0 = no slot loaded, 1 = one slot loaded, 2 = both slots loaded.
- R3: A control write with bit 4 (start) set, while control bit 3 (enable) is already set and at least one slot is loaded, begins the read phase on the next cycle. A start given while the channel is disabled has no effect.
- R4: Each word costs one read and then one write. The read goes to the active slot's source address and the write goes to its destination address, carrying the data just read. Both addresses then step by 4. A count of N bytes moves ceil(N/4) words. Status bits 3:1 read 2 during a read and 3 during a write.
- R5: While `mem_ready` is low, a pending memory request keeps `mem_req`, `mem_we` and `mem_addr` unchanged.
- R6: When the active slot finishes and the other slot is loaded, the next cycle is a read from the other slot. If control bit 21 is set, interrupt register bit 2 also becomes pending. With bit 21 clear, nothing becomes pending.
- R7: When the last loaded slot finishes, the control state becomes stall (1) and the buffer state becomes 0. Status bit 6 (done) then sets and stays set until software clears it.
- R8: Interrupt register bit 1 reads done ANDed with control bit 2. `irq` is the OR of interrupt bits 1 and 2. Writing the interrupt register clears each of bits 1 and 2 that is written as 0.
- R9: Starting the channel again does not clear done. Status can show done together with a read or write phase and a loaded slot.
- R10: A control write that clears enable while it was set returns the control state to idle (0) and the buffer state to 0 at the next edge. It also drops `mem_req` and discards the partly finished transfer. A later start with no slot reloaded does nothing.
- R11: A slot loaded while the other slot is running is chained without a stall, and its words are copied as well.
- R12: From stall, loading a slot and giving start resumes copying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |

## Verification
The bench builds the channel with its default parameters: 32-bit addresses and 16-bit counts. Byte counts from 4 to 64 are used, including 10, which is not a multiple of 4. These counts reach single-word slots, chained slots of unequal length, and a mid-transfer disable after several words. The memory model's ready is sometimes tied high and sometimes driven from a pseudo-random sequence. This places slot switches, refills and the disable at varied points of the read/write alternation, and the reference model follows every one of those cycles.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;

  localparam int REG_AW = 8;

  typedef enum logic [2:0] {
    CTL_IDLE  = 3'd0,
    CTL_STALL = 3'd1,
    CTL_RD    = 3'd2,
    CTL_WR    = 3'd3,
    CTL_BWAIT = 3'd4
  } ctl_st_e;

  typedef enum logic [1:0] {
    BUF_NONE = 2'd0,
    BUF_ONE  = 2'd1,
    BUF_TWO  = 2'd2
  } buf_st_e;

  localparam logic [REG_AW-1:0] OFF_CTRL = 8'h00;
  localparam logic [REG_AW-1:0] OFF_INT  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_STAT = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_CNT0 = 8'h10;
  localparam logic [REG_AW-1:0] OFF_CNT1 = 8'h14;
  localparam logic [REG_AW-1:0] OFF_SRC0 = 8'h18;
  localparam logic [REG_AW-1:0] OFF_SRC1 = 8'h1C;
  localparam logic [REG_AW-1:0] OFF_DST0 = 8'h20;
  localparam logic [REG_AW-1:0] OFF_DST1 = 8'h24;

  localparam int CB_DONE_IE = 2;
  localparam int CB_EN      = 3;
  localparam int CB_START   = 4;
  localparam int CB_NFB_IE  = 21;
  localparam int IB_DONE    = 1;
  localparam int IB_NFB     = 2;

endpackage

// File: rtl/dma_slot.sv
module dma_slot #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_cnt,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic [CW-1:0] wcnt,
  input  logic [AW-1:0] waddr,
  input  logic          step,
  output logic          armed,
  output logic          last,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst
);

  localparam logic [CW-1:0] WORD_B = CW'(4);
  localparam logic [AW-1:0] ADDR_STEP = AW'(4);

  assign last = (cnt <= WORD_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      src   <= '0;
      dst   <= '0;
    end else begin
      if (step) begin
        src <= src + ADDR_STEP;
        dst <= dst + ADDR_STEP;
        cnt <= last ? '0 : cnt - WORD_B;
        if (last) armed <= 1'b0;
      end
      if (wr_src) src <= waddr;
      if (wr_dst) dst <= waddr;
      if (wr_cnt) begin
        cnt   <= wcnt;
        armed <= (wcnt != '0);
      end
      if (flush) armed <= 1'b0;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    step && !last && !wr_cnt |=> cnt == $past(cnt) - WORD_B);

  // R7
  slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    step && last && !wr_cnt |=> !armed);

endmodule

// File: rtl/dma_ctl_fsm.sv
module dma_ctl_fsm
  import dma_m2m_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       halt,
  input  logic       go,
  input  logic [1:0] armed,
  input  logic       cur_last,
  input  logic       mem_ready,
  output ctl_st_e    st,
  output logic       cur,
  output logic       step,
  output logic       done_evt,
  output logic       nfb_evt
);

  logic oth;
  assign oth = ~cur;

  always_comb begin
    step     = (st == CTL_WR) && mem_ready;
    done_evt = step && cur_last && !armed[oth];
    nfb_evt  = step && cur_last && armed[oth];
  end

  always_ff @(posedge clk) begin
    if (rst || !en || halt) begin
      st  <= CTL_IDLE;
      cur <= 1'b0;
    end else begin
      case (st)
        CTL_IDLE, CTL_STALL:
          if (go && (armed != 2'b00)) begin
            st  <= CTL_RD;
            cur <= armed[cur] ? cur : oth;
          end
        CTL_RD:
          if (mem_ready) st <= CTL_WR;
        CTL_WR:
          if (step) begin
            if (cur_last) begin
              if (armed[oth]) begin
                cur <= oth;
                st  <= CTL_RD;
              end else begin
                st <= CTL_STALL;
              end
            end else begin
              st <= CTL_RD;
            end
          end
        default: st <= CTL_IDLE;
      endcase
    end
  end

  // R4
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (rst)
    st == CTL_RD && mem_ready && en && !halt |=> st == CTL_WR);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st == CTL_IDLE && !go |=> st == CTL_IDLE);

endmodule

// File: rtl/dma_m2m_chan.sv
module dma_m2m_chan
  import dma_m2m_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);

  localparam int NSLOT = 2;

  logic             en_q, done_ie, nfb_ie, done_q, nfb_q;
  logic             ctrl_wr, int_wr, en_fall, go;
  logic [NSLOT-1:0] armed, last;
  logic [CW-1:0]    cnt [NSLOT];
  logic [AW-1:0]    src [NSLOT];
  logic [AW-1:0]    dst [NSLOT];
  logic [31:0]      data_q;
  ctl_st_e          ctl_st;
  buf_st_e          buf_st;
  logic             cur, step, done_evt, nfb_evt, cur_last;

  assign ctrl_wr = reg_we && (reg_addr == OFF_CTRL);
  assign int_wr  = reg_we && (reg_addr == OFF_INT);
  assign en_fall = ctrl_wr && en_q && !reg_wdata[CB_EN];
  assign go      = ctrl_wr && reg_wdata[CB_START];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dma_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .flush  (en_fall),
      .wr_cnt (reg_we && reg_addr == ((s == 0) ? OFF_CNT0 : OFF_CNT1)),
      .wr_src (reg_we && reg_addr == ((s == 0) ? OFF_SRC0 : OFF_SRC1)),
      .wr_dst (reg_we && reg_addr == ((s == 0) ? OFF_DST0 : OFF_DST1)),
      .wcnt   (reg_wdata[CW-1:0]),
      .waddr  (reg_wdata[AW-1:0]),
      .step   (step && (cur == 1'(s))),
      .armed  (armed[s]),
      .last   (last[s]),
      .cnt    (cnt[s]),
      .src    (src[s]),
      .dst    (dst[s])
    );
  end

  assign cur_last = last[cur];

  dma_ctl_fsm u_ctl (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .halt      (en_fall),
    .go        (go),
    .armed     (armed),
    .cur_last  (cur_last),
    .mem_ready (mem_ready),
    .st        (ctl_st),
    .cur       (cur),
    .step      (step),
    .done_evt  (done_evt),
    .nfb_evt   (nfb_evt)
  );

  always_comb begin
    case (armed)
      2'b00:   buf_st = BUF_NONE;
      2'b11:   buf_st = BUF_TWO;
      default: buf_st = BUF_ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      done_ie <= 1'b0;
      nfb_ie  <= 1'b0;
      done_q  <= 1'b0;
      nfb_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q    <= reg_wdata[CB_EN];
        done_ie <= reg_wdata[CB_DONE_IE];
        nfb_ie  <= reg_wdata[CB_NFB_IE];
      end
      if (done_evt) done_q <= 1'b1;
      else if (int_wr && !reg_wdata[IB_DONE]) done_q <= 1'b0;
      if (nfb_evt && nfb_ie) nfb_q <= 1'b1;
      else if (int_wr && !reg_wdata[IB_NFB]) nfb_q <= 1'b0;
      if (ctl_st == CTL_RD && mem_ready) data_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFF_CTRL: reg_rdata <= {10'd0, nfb_ie, 16'd0, 1'b0, en_q, done_ie, 2'd0};
        OFF_INT:  reg_rdata <= {29'd0, nfb_q, done_q && done_ie, 1'b0};
        OFF_STAT: reg_rdata <= {25'd0, done_q, buf_st, ctl_st, 1'b0};
        OFF_CNT0: reg_rdata <= 32'(cnt[0]);
        OFF_CNT1: reg_rdata <= 32'(cnt[1]);
        OFF_SRC0: reg_rdata <= 32'(src[0]);
        OFF_SRC1: reg_rdata <= 32'(src[1]);
        OFF_DST0: reg_rdata <= 32'(dst[0]);
        OFF_DST1: reg_rdata <= 32'(dst[1]);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign irq       = (done_q && done_ie) || nfb_q;
  assign mem_req   = (ctl_st == CTL_RD) || (ctl_st == CTL_WR);
  assign mem_we    = (ctl_st == CTL_WR);
  assign mem_addr  = mem_we ? dst[cur] : src[cur];
  assign mem_wdata = data_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready && !reg_we |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    done_evt && !reg_we |=> ctl_st == CTL_STALL && buf_st == BUF_NONE && done_q);

  // R6
  switch_chk: assert property (@(posedge clk) disable iff (rst)
    nfb_evt && !reg_we |=> ctl_st == CTL_RD && cur != $past(cur));

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> ctl_st == CTL_IDLE && buf_st == BUF_NONE && !mem_req);

endmodule

// File: tb/tb_dma_m2m_chan.sv
`timescale 1ns/1ps
module tb_dma_m2m_chan;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int wr_seen = 0;
  bit rnd_mode = 1'b0;
  bit ended = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m_st, m_cur;
  int m_cnt [2];
  int unsigned m_src [2];
  int unsigned m_dst [2];
  bit m_arm [2];
  bit m_en, m_die, m_nie, m_done, m_nfb;

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign mem_rdata = pat(mem_addr);

  dma_m2m_chan dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    int nb;
    nb = (m_arm[0] ? 1 : 0) + (m_arm[1] ? 1 : 0);
    return 32'((m_done ? 64 : 0) + nb * 16 + m_st * 2);
  endfunction

  function automatic logic [31:0] m_int();
    return 32'((m_nfb ? 4 : 0) + ((m_done && m_die) ? 2 : 0));
  endfunction

  // memory ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= rnd_mode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk)
    if (!rst && mem_req && mem_we && mem_ready) wr_seen++;

  // reference model, advanced on every edge
  always @(posedge clk) begin : mdl
    bit cw, iw, halt, go, wd, lw, oa;
    int o, nst, ncur;
    if (rst) begin
      m_st = 0; m_cur = 0; m_en = 0; m_die = 0; m_nie = 0; m_done = 0; m_nfb = 0;
      for (int i = 0; i < 2; i++) begin
        m_arm[i] = 0; m_cnt[i] = 0; m_src[i] = 0; m_dst[i] = 0;
      end
    end else begin
      cw   = reg_we && reg_addr == 8'h00;
      iw   = reg_we && reg_addr == 8'h04;
      halt = cw && m_en && !reg_wdata[3];
      go   = cw && reg_wdata[4];
      wd   = (m_st == 3) && mem_ready;
      o    = 1 - m_cur;
      lw   = wd && (m_cnt[m_cur] <= 4);
      oa   = m_arm[o];
      nst  = m_st;
      ncur = m_cur;
      if (!m_en || halt) begin
        nst = 0; ncur = 0;
      end else if (m_st == 0 || m_st == 1) begin
        if (go && (m_arm[0] || m_arm[1])) begin
          nst = 2; ncur = m_arm[m_cur] ? m_cur : o;
        end
      end else if (m_st == 2) begin
        if (mem_ready) nst = 3;
      end else if (wd) begin
        if (lw) begin
          if (oa) begin nst = 2; ncur = o; end
          else nst = 1;
        end else nst = 2;
      end
      if (lw && !oa) m_done = 1;
      else if (iw && !reg_wdata[1]) m_done = 0;
      if (lw && oa && m_nie) m_nfb = 1;
      else if (iw && !reg_wdata[2]) m_nfb = 0;
      if (wd) begin
        m_src[m_cur] += 4;
        m_dst[m_cur] += 4;
        if (lw) begin m_cnt[m_cur] = 0; m_arm[m_cur] = 0; end
        else m_cnt[m_cur] -= 4;
      end
      if (reg_we) begin
        case (reg_addr)
          8'h10: begin m_cnt[0] = int'(reg_wdata[15:0]); m_arm[0] = reg_wdata[15:0] != 0; end
          8'h14: begin m_cnt[1] = int'(reg_wdata[15:0]); m_arm[1] = reg_wdata[15:0] != 0; end
          8'h18: m_src[0] = reg_wdata;
          8'h1C: m_src[1] = reg_wdata;
          8'h20: m_dst[0] = reg_wdata;
          8'h24: m_dst[1] = reg_wdata;
          default: ;
        endcase
      end
      if (halt) begin m_arm[0] = 0; m_arm[1] = 0; end
      if (cw) begin m_en = reg_wdata[3]; m_die = reg_wdata[2]; m_nie = reg_wdata[21]; end
      m_st  = nst;
      m_cur = ncur;
    end
  end

  // per-cycle comparison of the memory port and irq (R4, R5, R6, R8)
  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk(mem_req == (m_st == 2 || m_st == 3), "R4 mem_req", 32'(mem_req),
          32'(m_st == 2 || m_st == 3));
      if (mem_req) begin
        chk(mem_we == (m_st == 3), "R4 mem_we", 32'(mem_we), 32'(m_st == 3));
        chk(mem_addr == ((m_st == 3) ? m_dst[m_cur] : m_src[m_cur]), "R4 mem_addr",
            mem_addr, (m_st == 3) ? m_dst[m_cur] : m_src[m_cur]);
        if (mem_we)
          chk(mem_wdata == pat(m_src[m_cur]), "R4 mem_wdata", mem_wdata, pat(m_src[m_cur]));
      end
      chk(irq == (m_int() != 0), "R8 irq", 32'(irq), 32'(m_int() != 0));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] exp_stat);
    @(negedge clk);
    reg_addr = a;
    exp_stat = (a == 8'h04) ? m_int() : m_status();
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_stall(input string req);
    int n;
    n = 0;
    while (m_st != 1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(m_st == 1, req, 32'(m_st), 32'd1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  localparam logic [31:0] C_EN  = 32'h0000_0008;
  localparam logic [31:0] C_DIE = 32'h0000_0004;
  localparam logic [31:0] C_NIE = 32'h0020_0000;
  localparam logic [31:0] C_GO  = 32'h0000_0010;

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v, e;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h0C, v, e);
    chk(v == 32'd0, "R1 status", v, 32'd0);
    chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq/req", {30'd0, irq, mem_req}, 32'd0);

    // R2 load slot 0, start while disabled is ignored (R3)
    wr(8'h18, 32'h0000_1000);
    wr(8'h20, 32'h0000_8000);
    wr(8'h10, 32'd16);
    rd(8'h0C, v, e);
    chk(v == 32'h10, "R2 one slot", v, 32'h10);
    wr(8'h00, C_GO);
    repeat (5) @(negedge clk);
    chk(mem_req == 1'b0, "R3 start while disabled", 32'(mem_req), 32'd0);
    rd(8'h0C, v, e);
    chk(v == 32'h10, "R3 status unchanged", v, 32'h10);

    // R3/R4/R7/R8 single slot copy
    base = wr_seen;
    wr(8'h00, C_EN | C_DIE | C_NIE);
    wr(8'h00, C_EN | C_DIE | C_NIE | C_GO);
    chk(mem_req && !mem_we, "R3 read phase after start", {30'd0, mem_req, mem_we}, 32'd2);
    wait_stall("R7 reaches stall");
    chk(wr_seen - base == 4, "R4 words for 16 bytes", 32'(wr_seen - base), 32'd4);
    rd(8'h0C, v, e);
    chk(v == 32'h42, "R7 done+stall+none", v, 32'h42);
    rd(8'h04, v, e);
    chk(v == 32'h2, "R8 done interrupt", v, 32'h2);
    chk(irq == 1'b1, "R8 irq high", 32'(irq), 32'd1);
    rd(8'h10, v, e);
    chk(v == 32'd0, "R2 count drained", v, 32'd0);
    wr(8'h04, 32'd0);
    rd(8'h04, v, e);
    chk(v == 32'd0, "R8 cleared", v, 32'd0);

    // R6/R12 double buffer with random ready, 8 and 10 byte slots
    rnd_mode = 1'b1;
    wr(8'h18, 32'h0000_2000);
    wr(8'h20, 32'h0000_9000);
    wr(8'h10, 32'd8);
    wr(8'h1C, 32'h0000_3000);
    wr(8'h24, 32'h0000_A000);
    wr(8'h14, 32'd10);
    rd(8'h0C, v, e);
    chk(v == 32'h22, "R2 both slots", v, 32'h22);
    base = wr_seen;
    wr(8'h00, C_EN | C_DIE | C_NIE | C_GO);
    wait_stall("R12 resume from stall");
    chk(wr_seen - base == 5, "R6 chained words 2+3", 32'(wr_seen - base), 32'd5);
    rd(8'h04, v, e);
    chk(v == 32'h6, "R6 next-free pending", v, 32'h6);

    // R9/R11 done kept while running, refill during run
    wr(8'h04, 32'h2);
    rd(8'h04, v, e);
    chk(v == 32'h2, "R8 selective clear", v, 32'h2);
    wr(8'h18, 32'h0000_4000);
    wr(8'h20, 32'h0000_B000);
    wr(8'h10, 32'd32);
    base = wr_seen;
    wr(8'h00, C_EN | C_DIE | C_NIE | C_GO);
    rd(8'h0C, v, e);
    chk(v == e, "R9 status matches model", v, e);
    chk(v[6] && (v[3:1] == 3'd2 || v[3:1] == 3'd3) && v[5:4] == 2'd1,
        "R9 done while moving", v, e);
    wr(8'h1C, 32'h0000_5000);
    wr(8'h24, 32'h0000_C000);
    wr(8'h14, 32'd8);
    rd(8'h0C, v, e);
    chk(v[5:4] == 2'd2 && v == e, "R11 second slot queued", v, e);
    wait_stall("R11 chain completes");
    chk(wr_seen - base == 10, "R11 words 8+2", 32'(wr_seen - base), 32'd10);

    // R6 next-free interrupt disabled
    wr(8'h04, 32'd0);
    rnd_mode = 1'b0;
    wr(8'h00, C_EN | C_DIE);
    wr(8'h10, 32'd4);
    wr(8'h14, 32'd4);
    wr(8'h00, C_EN | C_DIE | C_GO);
    wait_stall("R6 run without next-free enable");
    rd(8'h04, v, e);
    chk(v == 32'h2, "R6 no next-free when disabled", v, 32'h2);
    wr(8'h04, 32'd0);

    // R10 disable mid transfer
    rnd_mode = 1'b1;
    wr(8'h18, 32'h0000_6000);
    wr(8'h20, 32'h0000_D000);
    wr(8'h10, 32'd64);
    wr(8'h00, C_EN | C_DIE | C_GO);
    repeat (6) @(negedge clk);
    wr(8'h00, C_DIE);
    chk(mem_req == 1'b0, "R10 request dropped", 32'(mem_req), 32'd0);
    rd(8'h0C, v, e);
    chk(v[5:1] == 5'd0, "R10 idle and no buffer", v, 32'd0);
    wr(8'h00, C_EN | C_DIE);
    wr(8'h00, C_EN | C_DIE | C_GO);
    repeat (5) @(negedge clk);
    chk(mem_req == 1'b0, "R10 partial discarded", 32'(mem_req), 32'd0);
    rd(8'h0C, v, e);
    chk(v == e && v[3:1] == 3'd0, "R10 status after restart attempt", v, e);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule